// File: doc/BRIEF.md
# Three-Level Accumulator Push-Down Stack

This block holds one accumulator-style register of an 8/16-bit processor datapath as a three-entry push-down stack: a top entry, a second entry and a third entry. The datapath writes the top entry through a load port and reads it through a read port. Loads never push the stack and reads never pop it. Moving data between entries happens only through an explicit stack command. The available commands are push, pop, exchange of the top two entries, a swap of the two bytes of the top entry, and a reversal of the bit order of the top entry.

Each entry is 16 bits wide. A width-select input chooses between the default narrow (8-bit) view and the wide (16-bit) view. In the narrow view the upper byte that the datapath sees is forced to zero, and a narrow load stores zero in the upper byte. All state updates happen on the rising clock edge. The read port is a mask applied to the registered top entry.

Top module: `regstack`

## Requirements
- R1: A synchronous active-high reset clears all three entries to zero, so the read port shows 0x0000 and later pops also return 0x0000.
- R2: A load (`ld_en`=1 with command NOP) writes only the top entry. The second and third entries keep their values.
- R3: Reading the top entry through `rd_data` never changes the stack. Repeated NOP cycles return the same value.
- R4: Command PUSH (code 1) copies top into second and second into third. The old third value is lost and top is unchanged.
- R5: Command POP (code 2) moves second into top and third into second. The third entry keeps its value.
- R6: Command XCHG (code 3) swaps the top and second entries in one cycle.
- R7: Command BSWAP (code 4) exchanges bits [15:8] and [7:0] of the top entry.
- R8: Command BREV (code 5) reverses the bit order of the top entry, so that bit i moves to bit 15-i.
- R9: When `wide`=0, `rd_data[15:8]` reads zero, and a load stores zero in the upper byte of the top entry.
- R10: When a load and a stack command arrive in the same cycle, the command runs first and the load then overwrites the new top.
- R11: Codes 0, 6 and 7 leave all entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wide | input | 1 | 1 selects the 16-bit view, 0 selects the 8-bit view |
| ld_en | input | 1 | Write `ld_data` into the top entry |
| ld_data | input | 16 | Load value |
| cmd | input | 3 | Stack command: 0 NOP, 1 PUSH, 2 POP, 3 XCHG, 4 BSWAP, 5 BREV, 6-7 NOP |
| rd_data | output | 16 | Top entry, with the upper byte masked in narrow view |

## Verification
The bench fills all three levels with distinct values and pushes once more. A design that kept the oldest entry, or dropped the wrong one, would then pop the wrong sequence. Pops continue past the depth of the stack, which catches a third entry that is cleared or shifted instead of held. A combined push and load in one cycle checks the ordering: an implementation that loads first would push the new value into second. Narrow loads are read back later in wide view, which exposes a stored upper byte that was only hidden by the read mask. An asymmetric bit pattern is used to catch a byte swap or bit reversal that is mis-indexed.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_XCHG  = 3'd3,
    OP_BSWAP = 3'd4,
    OP_BREV  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } stk_op_e;
endpackage

// File: rtl/regstack_perm.sv
// Permutation unit for the top entry: byte swap and bit reversal.
module regstack_perm #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         do_swap,
  input  logic         do_rev,
  output logic [W-1:0] dout
);
  localparam int HALF = W / 2;

  logic [W-1:0] swapped;
  logic [W-1:0] reversed;

  assign swapped = {din[HALF-1:0], din[W-1:HALF]};

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign reversed[i] = din[W-1-i];
  end

  always_comb begin
    if (do_swap)     dout = swapped;
    else if (do_rev) dout = reversed;
    else             dout = din;
  end

  always_comb begin
    if (do_swap && !do_rev)
      AST_SWAP_INVOLUTION: assert ({dout[HALF-1:0], dout[W-1:HALF]} == din); // R7
    if (do_rev && !do_swap)
      AST_REV_ENDS: assert (dout[0] == din[W-1] && dout[W-1] == din[0]); // R8
  end
endmodule

// File: rtl/regstack_store.sv
// Three-entry storage with command sequencing; a load overrides the new top.
module regstack_store
  import regstack_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  stk_op_e      op,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] perm_val,
  output logic [W-1:0] top_q,
  output logic [W-1:0] sec_q,
  output logic [W-1:0] thd_q
);
  logic [W-1:0] top_d, sec_d, thd_d;

  always_comb begin
    top_d = top_q;
    sec_d = sec_q;
    thd_d = thd_q;
    unique case (op)
      OP_PUSH: begin
        sec_d = top_q;
        thd_d = sec_q;
      end
      OP_POP: begin
        top_d = sec_q;
        sec_d = thd_q;
      end
      OP_XCHG: begin
        top_d = sec_q;
        sec_d = top_q;
      end
      OP_BSWAP, OP_BREV: top_d = perm_val;
      default: ;
    endcase
    if (ld_en) top_d = ld_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= '0;
      sec_q <= '0;
      thd_q <= '0;
    end else begin
      top_q <= top_d;
      sec_q <= sec_d;
      thd_q <= thd_d;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (top_q == '0 && sec_q == '0 && thd_q == '0)); // R1
  AST_LOAD_LOWER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ld_en && op == OP_NOP) |=> ($stable(sec_q) && $stable(thd_q))); // R2
  AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH && !ld_en) |=> (sec_q == $past(top_q) && thd_q == $past(sec_q) && $stable(top_q))); // R4
  AST_POP_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (op == OP_POP && !ld_en) |=> (top_q == $past(sec_q) && sec_q == $past(thd_q) && $stable(thd_q))); // R5
  AST_XCHG_SWAP: assert property (@(posedge clk) disable iff (rst)
    (op == OP_XCHG && !ld_en) |=> (top_q == $past(sec_q) && sec_q == $past(top_q) && $stable(thd_q))); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (top_q == $past(ld_val))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && (op == OP_NOP || op == OP_RSV6 || op == OP_RSV7))
      |=> ($stable(top_q) && $stable(sec_q) && $stable(thd_q))); // R11
endmodule

// File: rtl/regstack_mask.sv
// Width view: clears the upper half when the narrow view is selected.
module regstack_mask #(
  parameter int W = 16
) (
  input  logic         wide,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int HALF = W / 2;

  assign dout = wide ? din : {{HALF{1'b0}}, din[HALF-1:0]};
endmodule

// File: rtl/regstack.sv
// Three-level push-down stack for one accumulator register.
module regstack
  import regstack_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wide,
  input  logic         ld_en,
  input  logic [15:0]  ld_data,
  input  logic [2:0]   cmd,
  output logic [15:0]  rd_data
);
  localparam int HALF = W / 2;

  stk_op_e      op;
  logic [W-1:0] ld_masked;
  logic [W-1:0] perm_out;
  logic [W-1:0] top_q, sec_q, thd_q;

  assign op = stk_op_e'(cmd);

  regstack_mask #(.W(W)) u_ld_mask (
    .wide (wide),
    .din  (ld_data),
    .dout (ld_masked)
  );

  regstack_perm #(.W(W)) u_perm (
    .din     (top_q),
    .do_swap (op == OP_BSWAP),
    .do_rev  (op == OP_BREV),
    .dout    (perm_out)
  );

  regstack_store #(.W(W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .ld_en    (ld_en),
    .ld_val   (ld_masked),
    .perm_val (perm_out),
    .top_q    (top_q),
    .sec_q    (sec_q),
    .thd_q    (thd_q)
  );

  regstack_mask #(.W(W)) u_rd_mask (
    .wide (wide),
    .din  (top_q),
    .dout (rd_data)
  );

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    !wide |-> (rd_data[W-1:HALF] == '0)); // R9
  AST_NARROW_LOAD_STORE: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !wide) |=> (top_q[W-1:HALF] == '0)); // R9
endmodule

// File: tb/regstack_bench.sv
module regstack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  // {ld_en, cmd[2:0], wide, ld_data[15:0], expected rd_data[15:0]}
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 3'd0, 1'b1, 16'h1234, 16'h1234}, // R2 load
    {1'b0, 3'd1, 1'b1, 16'h0000, 16'h1234}, // R4 push keeps top
    {1'b1, 3'd0, 1'b1, 16'hABCD, 16'hABCD}, // R2 load
    {1'b1, 3'd1, 1'b1, 16'h5555, 16'h5555}, // R10 push then load
    {1'b0, 3'd3, 1'b1, 16'h0000, 16'hABCD}, // R6 exchange
    {1'b0, 3'd4, 1'b1, 16'h0000, 16'hCDAB}, // R7 byte swap
    {1'b0, 3'd5, 1'b1, 16'h0000, 16'hD5B3}, // R8 bit reverse
    {1'b0, 3'd2, 1'b1, 16'h0000, 16'h5555}, // R5 pop
    {1'b0, 3'd2, 1'b1, 16'h0000, 16'h1234}, // R5 pop
    {1'b0, 3'd2, 1'b1, 16'h0000, 16'h1234}, // R5 third held
    {1'b0, 3'd0, 1'b0, 16'h0000, 16'h0034}, // R9 narrow view
    {1'b1, 3'd0, 1'b0, 16'h9876, 16'h0076}, // R9 narrow load
    {1'b0, 3'd0, 1'b1, 16'h0000, 16'h0076}, // R9 upper stored zero
    {1'b0, 3'd6, 1'b1, 16'h0000, 16'h0076}, // R11 reserved
    {1'b0, 3'd7, 1'b1, 16'h0000, 16'h0076}, // R11 reserved
    {1'b1, 3'd0, 1'b1, 16'h1111, 16'h1111},
    {1'b1, 3'd1, 1'b1, 16'h2222, 16'h2222}, // R10
    {1'b1, 3'd1, 1'b1, 16'h3333, 16'h3333}, // R10
    {1'b1, 3'd1, 1'b1, 16'h4444, 16'h4444}, // R4 1111 lost
    {1'b0, 3'd0, 1'b1, 16'h0000, 16'h4444}, // R3 read no pop
    {1'b0, 3'd0, 1'b1, 16'h0000, 16'h4444}, // R3 read no pop
    {1'b0, 3'd2, 1'b1, 16'h0000, 16'h3333}, // R5
    {1'b0, 3'd2, 1'b1, 16'h0000, 16'h2222}, // R5
    {1'b0, 3'd2, 1'b1, 16'h0000, 16'h2222}, // R5 third held
    {1'b0, 3'd4, 1'b0, 16'h0000, 16'h0022}, // R7 swap, narrow view
    {1'b1, 3'd0, 1'b0, 16'hFFFF, 16'h00FF}  // R9
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        wide;
  logic        ld_en;
  logic [15:0] ld_data;
  logic [2:0]  cmd;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regstack u_regstack (
    .clk     (clk),
    .rst     (rst),
    .wide    (wide),
    .ld_en   (ld_en),
    .ld_data (ld_data),
    .cmd     (cmd),
    .rd_data (rd_data)
  );

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic step(input logic l, input logic [2:0] c, input logic w, input logic [15:0] d);
    ld_en = l; cmd = c; wide = w; ld_data = d;
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0; cmd = 3'd0;
  endtask

  initial begin
    rst = 1'b1; wide = 1'b1; ld_en = 1'b0; ld_data = '0; cmd = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset top", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][36], VEC[i][35:33], VEC[i][32], VEC[i][31:16]);
      check($sformatf("vector %0d", i), VEC[i][15:0]);
    end

    // R1: reset in the middle of use clears every level
    step(1'b1, 3'd0, 1'b1, 16'hBEEF);
    step(1'b0, 3'd1, 1'b1, 16'h0000);
    step(1'b0, 3'd1, 1'b1, 16'h0000);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset top", 16'h0000);
    step(1'b0, 3'd2, 1'b1, 16'h0000);
    check("R1 second cleared", 16'h0000);
    step(1'b0, 3'd2, 1'b1, 16'h0000);
    check("R1 third cleared", 16'h0000);

    // R8: single-bit patterns through bit reversal
    step(1'b1, 3'd0, 1'b1, 16'h0001);
    step(1'b0, 3'd5, 1'b1, 16'h0000);
    check("R8 reverse 0001", 16'h8000);
    // R6: exchange keeps third intact
    step(1'b1, 3'd1, 1'b1, 16'h00A5);
    step(1'b0, 3'd3, 1'b1, 16'h0000);
    check("R6 exchange", 16'h8000);
    step(1'b0, 3'd2, 1'b1, 16'h0000);
    check("R6 exchange moved", 16'h00A5);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: expired, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule